// File: doc/BRIEF.md
# Chained FIFO Depth Expansion Controller

This block is the control slice of one FIFO device that can either run alone or sit in a ring of identical devices that together form a deeper buffer. It owns the local write and read address counters and the fill level, and it decides whether a write strobe or read strobe arriving on the shared bus is meant for this device. Only the device holding the write token accepts writes, and only the device holding the read token accepts reads. The memory array itself and any merging of flags across devices belong to other blocks.

In chained mode two token pulses move around the ring. When a device accepts the write that lands on its last address, it raises a one-cycle write pulse. The next device in the ring takes that pulse on its expansion input and holds the write token from the following cycle on. The read token moves the same way. The first-load strap picks the device that owns both tokens after reset. In single mode, selected by the `single_sel` strap (which stands for an expansion input tied low), the device always holds both tokens. The shared output then reports the half-full flag, and the first-load pin becomes a retransmit request.

Top module: `exp_chain_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) both address counters and the level are zero, `empty`=1 and `full`=0. A chained device with `first_n`=0 holds both tokens, a chained device with `first_n`=1 holds none, and a single-mode device holds both.
- R2: A write is accepted (`wr_en`=1 in the same cycle) only when `wr_stb`=1, the write token is held, `full`=0, reset is released and no retransmit is requested. Each accepted write advances `wr_addr` by one on the next edge, and the address wraps from DEPTH-1 to 0.
- R3: A read is accepted (`rd_en`=1) only when `rd_stb`=1, the read token is held, `empty`=0, reset is released and no retransmit is requested. A device without the read token keeps `rd_en`=0, so its output stays invalid. Each accepted read advances `rd_addr` with the same wrap rule.
- R4: In chained mode `exp_hf[0]` is 1 exactly in the cycle of an accepted write to address DEPTH-1, and the write token is dropped from the next cycle on unless `exp_in[0]` grants it back in that same cycle.
- R5: In chained mode `exp_hf[1]` is 1 exactly in the cycle of an accepted read from address DEPTH-1, and the read token is dropped from the next cycle on unless `exp_in[1]` grants it back.
- R6: In chained mode a 1 on `exp_in[0]` (write) or `exp_in[1]` (read) at a clock edge gives the device that token from the next cycle on.
- R7: In single mode both tokens are always held. `exp_hf[1]` is 0, and `exp_hf[0]` is the half-full flag, which is 1 when the level is greater than DEPTH/2.
- R8: The level rises by one for each accepted write and falls by one for each accepted read. `full` is 1 when the level equals DEPTH, and `empty` is 1 when it equals 0. A write strobe while full and a read strobe while empty have no effect.
- R9: In single mode, `first_n`=0 at an edge sets `rd_addr` to 0 and sets the level to the current `wr_addr` (valid when fewer than DEPTH writes have been made since reset). Strobes are ignored in that cycle.
- R10: In chained mode `first_n` has no retransmit effect: a chained device strapped with `first_n`=0 moves its read address only on accepted reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_sel | input | 1 | Strap: 1 = single-device mode (expansion input grounded) |
| first_n | input | 1 | Chained: 0 marks the first device. Single: 0 requests retransmit |
| exp_in | input | 2 | Token pulses from previous device: [0] write, [1] read |
| wr_stb | input | 1 | Write strobe on the shared bus |
| rd_stb | input | 1 | Read strobe on the shared bus |
| wr_en | output | 1 | Accepted write to local memory |
| wr_addr | output | AW | Local write address |
| rd_en | output | 1 | Accepted read; local output valid |
| rd_addr | output | AW | Local read address |
| full | output | 1 | Local memory full |
| empty | output | 1 | Local memory empty |
| exp_hf | output | 2 | Chained: {read pulse, write pulse}. Single: {0, half-full} |
| wr_tok | output | 1 | Write token held |
| rd_tok | output | 1 | Read token held |

## Verification
A two-device ring and a separate single-mode device are driven side by side. The ring is first filled past its combined capacity. This shows whether the write token returns to a device that is still full and whether the extra strobes are dropped there. It is then drained past empty, which tests the read-token hand-off in the same way. A retransmit in the middle of a partial drain tells apart a read address reset to zero from a level restored to the write address. A long mixed phase with strobes and retransmits on random cycles then catches pulses that come one cycle early or late, and any token held by both ring members at once.

// File: rtl/exp_pkg.sv
// Shared definitions for the depth expansion controller.
// Assumes: index 0 of every direction pair is the write side, 1 the read side.
package exp_pkg;
    localparam int DIR_WR = 0;
    localparam int DIR_RD = 1;
    localparam int NDIR   = 2;

    typedef enum logic {
        MODE_CHAIN  = 1'b0,
        MODE_SINGLE = 1'b1
    } exp_mode_e;
endpackage

// File: rtl/exp_token.sv
// Holds one access token (write or read) for a device.
// Assumes: grant comes from the previous device's pass pulse; in single
// mode the token is pinned high.
module exp_token (
    input  logic clk,
    input  logic rst_n,
    input  logic single,
    input  logic init_own,
    input  logic grant,
    input  logic pass,
    output logic own
);
    // Token register: reset value from strap, then pass/grant updates.
    always_ff @(posedge clk) begin
        if (!rst_n)
            own <= init_own | single;
        else if (single)
            own <= 1'b1;
        else
            own <= (own & ~pass) | grant;
    end
endmodule

// File: rtl/exp_ptr.sv
// Wrapping address counter over DEPTH locations.
// Assumes: clear has priority over step; at_last flags the current address.
module exp_ptr #(
    parameter int DEPTH = 512,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          clear,
    output logic [AW-1:0] ptr,
    output logic          at_last
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign at_last = (ptr == LAST);

    // Address update: clear, wrap at the last location, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (clear)
            ptr <= '0;
        else if (step)
            ptr <= at_last ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/exp_level.sv
// Local fill level with full, empty and half-full flags.
// Assumes: inc is never set when full, dec never when empty; load wins.
module exp_level #(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          full,
    output logic          empty,
    output logic          half
);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    logic [CW-1:0] level;

    assign full  = (level == CAP);
    assign empty = (level == '0);
    assign half  = (level > HALF);

    // Level register: load on retransmit, otherwise net of accepted accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= '0;
        else if (load)
            level <= load_val;
        else if (inc && !dec)
            level <= level + 1'b1;
        else if (dec && !inc)
            level <= level - 1'b1;
    end
endmodule

// File: rtl/exp_chain_ctrl.sv
// Depth expansion controller for one FIFO device of a token ring.
// Assumes: single_sel and (in chained mode) first_n are static straps;
// exp_in of each device is wired to exp_hf of the previous device.
module exp_chain_ctrl #(
    parameter int DEPTH = 512,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          single_sel,
    input  logic          first_n,
    input  logic [1:0]    exp_in,
    input  logic          wr_stb,
    input  logic          rd_stb,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          full,
    output logic          empty,
    output logic [1:0]    exp_hf,
    output logic          wr_tok,
    output logic          rd_tok
);
    import exp_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    exp_mode_e       mode;
    logic            retx;
    logic            half;
    logic [NDIR-1:0] stb, acc, own, last, pass, clr;
    logic [AW-1:0]   ptr [NDIR];

    assign mode = single_sel ? MODE_SINGLE : MODE_CHAIN;
    assign retx = (mode == MODE_SINGLE) && !first_n;

    assign stb[DIR_WR] = wr_stb && !full;
    assign stb[DIR_RD] = rd_stb && !empty;
    assign clr[DIR_WR] = 1'b0;
    assign clr[DIR_RD] = retx;

    // One token and one address counter per direction.
    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        assign acc[g]  = rst_n && !retx && stb[g] && own[g];
        assign pass[g] = acc[g] && last[g] && (mode == MODE_CHAIN);

        exp_token u_tok (
            .clk      (clk),
            .rst_n    (rst_n),
            .single   (mode == MODE_SINGLE),
            .init_own (!first_n),
            .grant    (exp_in[g] && (mode == MODE_CHAIN)),
            .pass     (pass[g]),
            .own      (own[g])
        );

        exp_ptr #(.DEPTH(DEPTH)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (acc[g]),
            .clear   (clr[g]),
            .ptr     (ptr[g]),
            .at_last (last[g])
        );
    end

    exp_level #(.DEPTH(DEPTH)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (acc[DIR_WR]),
        .dec      (acc[DIR_RD]),
        .load     (retx && rst_n),
        .load_val (CW'(ptr[DIR_WR])),
        .full     (full),
        .empty    (empty),
        .half     (half)
    );

    // Shared pin: token pulses when chained, half-full when alone.
    always_comb begin
        if (mode == MODE_SINGLE)
            exp_hf = {1'b0, half};
        else
            exp_hf = {pass[DIR_RD], pass[DIR_WR]};
    end

    assign wr_en   = acc[DIR_WR];
    assign rd_en   = acc[DIR_RD];
    assign wr_addr = ptr[DIR_WR];
    assign rd_addr = ptr[DIR_RD];
    assign wr_tok  = own[DIR_WR];
    assign rd_tok  = own[DIR_RD];
endmodule

// File: rtl/exp_chain_chk.sv
// Property checker for exp_chain_ctrl, attached by bind.
// Assumes: straps are static while rst_n is high.
module exp_chain_chk #(
    parameter int DEPTH = 512,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          single_sel,
    input logic          first_n,
    input logic [1:0]    exp_in,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          full,
    input logic          empty,
    input logic [1:0]    exp_hf,
    input logic          wr_tok,
    input logic          rd_tok
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    a_r2_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_tok && !full));

    a_r2_write_advance: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_addr == (($past(wr_addr) == LAST) ? '0 : $past(wr_addr) + 1'b1)));

    a_r3_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_tok && !empty));

    a_r4_wpulse_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_sel && exp_hf[0]) |-> (wr_en && wr_addr == LAST));

    a_r4_wtoken_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_sel && exp_hf[0] && !exp_in[0]) |=> !wr_tok);

    a_r5_rtoken_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_sel && exp_hf[1] && !exp_in[1]) |=> !rd_tok);

    a_r6_wgrant: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_sel && exp_in[0]) |=> wr_tok);

    a_r6_rgrant: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_sel && exp_in[1]) |=> rd_tok);

    a_r7_single_tokens: assert property (@(posedge clk) disable iff (!rst_n)
        single_sel |-> (wr_tok && rd_tok && !exp_hf[1]));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    a_r9_retransmit: assert property (@(posedge clk) disable iff (!rst_n)
        (single_sel && !first_n) |=> (rd_addr == '0));
endmodule

bind exp_chain_ctrl exp_chain_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .single_sel (single_sel),
    .first_n    (first_n),
    .exp_in     (exp_in),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .full       (full),
    .empty      (empty),
    .exp_hf     (exp_hf),
    .wr_tok     (wr_tok),
    .rd_tok     (rd_tok)
);

// File: tb/sim_exp_chain_ctrl.sv
// Bench: two-device ring (u0 first, u1) plus one single-mode device (u2),
// compared every cycle against a behavioural model.
module sim_exp_chain_ctrl;
    localparam int D  = 8;
    localparam int AW = $clog2(D);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic cws = 0, crs = 0, sws = 0, srs = 0, sfl = 1;

    logic          wr_en_o [3];
    logic [AW-1:0] wr_addr_o [3];
    logic          rd_en_o [3];
    logic [AW-1:0] rd_addr_o [3];
    logic          full_o [3];
    logic          empty_o [3];
    logic [1:0]    hf_o [3];
    logic          wt_o [3];
    logic          rt_o [3];

    exp_chain_ctrl #(.DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .single_sel(1'b0), .first_n(1'b0),
        .exp_in(hf_o[1]), .wr_stb(cws), .rd_stb(crs),
        .wr_en(wr_en_o[0]), .wr_addr(wr_addr_o[0]), .rd_en(rd_en_o[0]),
        .rd_addr(rd_addr_o[0]), .full(full_o[0]), .empty(empty_o[0]),
        .exp_hf(hf_o[0]), .wr_tok(wt_o[0]), .rd_tok(rt_o[0]));

    exp_chain_ctrl #(.DEPTH(D)) u1 (
        .clk(clk), .rst_n(rst_n), .single_sel(1'b0), .first_n(1'b1),
        .exp_in(hf_o[0]), .wr_stb(cws), .rd_stb(crs),
        .wr_en(wr_en_o[1]), .wr_addr(wr_addr_o[1]), .rd_en(rd_en_o[1]),
        .rd_addr(rd_addr_o[1]), .full(full_o[1]), .empty(empty_o[1]),
        .exp_hf(hf_o[1]), .wr_tok(wt_o[1]), .rd_tok(rt_o[1]));

    exp_chain_ctrl #(.DEPTH(D)) u2 (
        .clk(clk), .rst_n(rst_n), .single_sel(1'b1), .first_n(sfl),
        .exp_in(2'b00), .wr_stb(sws), .rd_stb(srs),
        .wr_en(wr_en_o[2]), .wr_addr(wr_addr_o[2]), .rd_en(rd_en_o[2]),
        .rd_addr(rd_addr_o[2]), .full(full_o[2]), .empty(empty_o[2]),
        .exp_hf(hf_o[2]), .wr_tok(wt_o[2]), .rd_tok(rt_o[2]));

    // Behavioural model state.
    int wp[3], rp[3], cn[3], wt[3], rt[3];
    int ew[3], er[3], pw[3], pr[3], rtx_prev;
    int nchk = 0, nerr = 0;
    bit armed = 0, done = 0;
    int tap[$];   // chain occupancy tracker: device index of each stored word

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void comb();
        for (int d = 0; d < 3; d++) begin
            bit single = (d == 2);
            bit rtx = single && !sfl;
            bit ws = single ? sws : cws;
            bit rs = single ? srs : crs;
            ew[d] = (rst_n && !rtx && ws && wt[d] != 0 && cn[d] < D) ? 1 : 0;
            er[d] = (rst_n && !rtx && rs && rt[d] != 0 && cn[d] > 0) ? 1 : 0;
            pw[d] = (!single && ew[d] != 0 && wp[d] == D - 1) ? 1 : 0;
            pr[d] = (!single && er[d] != 0 && rp[d] == D - 1) ? 1 : 0;
        end
    endfunction

    function automatic void advance();
        int gi_w[3], gi_r[3];
        gi_w[0] = pw[1]; gi_r[0] = pr[1];
        gi_w[1] = pw[0]; gi_r[1] = pr[0];
        gi_w[2] = 0;     gi_r[2] = 0;
        rtx_prev = (rst_n && !sfl) ? 1 : 0;
        for (int d = 0; d < 3; d++) begin
            bit single = (d == 2);
            if (!rst_n) begin
                wp[d] = 0; rp[d] = 0; cn[d] = 0;
                wt[d] = (d != 1) ? 1 : 0;
                rt[d] = (d != 1) ? 1 : 0;
            end else begin
                if (single) begin
                    wt[d] = 1; rt[d] = 1;
                end else begin
                    wt[d] = ((wt[d] != 0 && pw[d] == 0) || gi_w[d] != 0) ? 1 : 0;
                    rt[d] = ((rt[d] != 0 && pr[d] == 0) || gi_r[d] != 0) ? 1 : 0;
                end
                if (single && !sfl) begin
                    cn[d] = wp[d];
                    rp[d] = 0;
                end else begin
                    cn[d] = cn[d] + ew[d] - er[d];
                    if (er[d] != 0) rp[d] = (rp[d] + 1) % D;
                end
                if (ew[d] != 0) wp[d] = (wp[d] + 1) % D;
                if (!single) begin
                    if (ew[d] != 0) tap.push_back(d);
                    if (er[d] != 0) begin
                        if (tap.size() == 0 || tap[0] != d) begin
                            nerr++;
                            $display("FAIL R3: chain read order actual=%0d expected=%0d", d,
                                     (tap.size() == 0) ? -1 : tap[0]);
                        end
                        nchk++;
                        if (tap.size() != 0) void'(tap.pop_front());
                    end
                end
            end
        end
    endfunction

    task automatic compare();
        for (int d = 0; d < 3; d++) begin
            int exph;
            if (d == 2) exph = (cn[d] > D / 2) ? 1 : 0;
            else        exph = pr[d] * 2 + pw[d];
            chk("R2 wr_en", int'(wr_en_o[d]), ew[d]);
            chk("R2 wr_addr", int'(wr_addr_o[d]), wp[d]);
            chk("R3 rd_en", int'(rd_en_o[d]), er[d]);
            if (d == 2 && rtx_prev != 0) chk("R9 rd_addr", int'(rd_addr_o[d]), rp[d]);
            else if (d == 0)             chk("R3/R10 rd_addr", int'(rd_addr_o[d]), rp[d]);
            else                         chk("R3 rd_addr", int'(rd_addr_o[d]), rp[d]);
            chk("R8 full", int'(full_o[d]), (cn[d] == D) ? 1 : 0);
            chk("R8 empty", int'(empty_o[d]), (cn[d] == 0) ? 1 : 0);
            if (d == 2) begin
                chk("R7 exp_hf", int'(hf_o[d]), exph);
                chk("R7 tokens", int'({wt_o[d], rt_o[d]}), 3);
            end else begin
                chk("R4/R5 exp_hf", int'(hf_o[d]), exph);
                chk("R6 wr_tok", int'(wt_o[d]), wt[d]);
                chk("R6 rd_tok", int'(rt_o[d]), rt[d]);
            end
        end
    endtask

    task automatic step(bit cw, bit cr, bit sw, bit sr, bit fl);
        cws = cw; crs = cr; sws = sw; srs = sr; sfl = fl;
        #5;
        comb();
        if (armed) compare();
        @(posedge clk);
        advance();
        armed = 1;
        @(negedge clk);
    endtask

    initial begin
        for (int d = 0; d < 3; d++) begin
            wp[d] = 0; rp[d] = 0; cn[d] = 0; wt[d] = 0; rt[d] = 0;
        end
        rtx_prev = 0;
        @(negedge clk);
        repeat (3) step(0, 0, 0, 0, 1);
        rst_n = 1'b1;
        // R1: reset state seen before any access.
        #1;
        chk("R1 u0 tokens", int'({wt_o[0], rt_o[0]}), 3);
        chk("R1 u1 tokens", int'({wt_o[1], rt_o[1]}), 0);
        chk("R1 u2 tokens", int'({wt_o[2], rt_o[2]}), 3);
        chk("R1 u1 empty", int'(empty_o[1]), 1);
        chk("R1 u0 full", int'(full_o[0]), 0);
        chk("R1 u2 wr_addr", int'(wr_addr_o[2]), 0);
        // Fill ring past capacity (R4, R8); single device to half-full (R7).
        for (int i = 0; i < 12; i++) step(1, 0, i < 6, 0, 1);
        for (int i = 0; i < 6; i++)  step(1, 0, 0, i < 3, 1);
        // R9: retransmit on single device, then drain past empty.
        step(0, 0, 1, 1, 0);
        // Drain ring past empty (R5, R3).
        for (int i = 0; i < 20; i++) step(0, 1, 0, i < 9, 1);
        // Overfill single device (R8).
        for (int i = 0; i < 11; i++) step(0, 0, 1, 0, 1);
        for (int i = 0; i < 9; i++)  step(0, 0, 0, 1, 1);
        // Mixed traffic with random strobes and occasional retransmit.
        for (int i = 0; i < 600; i++)
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 15) != 0));
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule